// File: doc/BRIEF.md
# Circular Voltage Limit by Newton Square Root

This block works out how much q-axis voltage a current controller may still command once the d-axis voltage is known, so that the voltage vector stays inside a circle of fixed radius. It takes a signed d-axis voltage in Q14 format, which is 16 bits, two's complement, with 0x3FFF standing for full scale. A one-cycle start strobe begins the work. The block forms the radicand full-scale² − vd². It then takes the integer square root by running a fixed number of Newton steps from a constant first guess. Each step uses a sequential shift-subtract divider.

When the work ends, the unsigned limit appears on the output together with a one-cycle done pulse. The limit stays on the output until the next operation finishes. The run time does not depend on the data, apart from the case where the radicand is zero. That case finishes on the next clock edge.

Top module: `sqrtlim_newton`

## Requirements
- R1: The radicand is a = 16383² − vd², where vd is the two's-complement value of `vd_i` and 16383 (0x3FFF) is full scale.
- R2: For a ≥ 1, `limit_o` equals x8 of the recurrence x0 = 500, xn = floor((xn-1 + floor(a / xn-1)) / 2). This holds across the whole range 1 to 16383².
- R3: When |vd| ≥ 16383, including vd = −32768, the radicand is zero. The iteration is then skipped and `limit_o` = 0 with `done_o` on the next edge.
- R4: Each divider result is the exact floor quotient of the radicand by the current estimate, so that quotient × estimate ≤ a < (quotient + 1) × estimate.
- R5: `done_o` is high for exactly one cycle per operation.
- R6: `limit_o` holds its value from one done pulse until the next one, whatever happens on `vd_i`.
- R7: A start strobe that arrives while an operation is in progress is ignored. That operation completes with its own input.
- R8: After reset, `done_o` = 0 and `limit_o` = 0.
- R9: The estimate is never zero while the iteration runs, and every new estimate fits in the estimate register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that captures `vd_i` and starts an operation |
| vd_i | input | 16 | Signed Q14 d-axis voltage |
| done_o | output | 1 | One-cycle pulse when `limit_o` is updated |
| limit_o | output | 16 | Unsigned q-axis voltage limit |

## Verification
The divider checks assume that the dividend and the divisor do not change while a division runs, and that the divider is never started while it is busy. The top-level sequencer guarantees both, because it holds the radicand and the estimate until the quotient comes back. The checks on the output assume that `start_i` is a clean strobe. The stimulus raises `start_i` for a single cycle only. It changes `vd_i` freely between operations and during an operation, because the input is captured only at the start. The sweep covers the valid range of vd at a fixed stride, plus the values at and beyond full scale.

// File: rtl/sqrtlim_pkg.sv
package sqrtlim_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sqrtlim_radicand.sv
module sqrtlim_radicand #(
    parameter int DATA_W = 16,
    parameter int RAD_W  = 2 * (DATA_W - 2)
) (
    input  logic [DATA_W-1:0] vd_i,
    output logic [RAD_W-1:0]  rad_o,
    output logic              zero_o
);
    localparam int MAG_W = DATA_W - 2;
    localparam int FS_N  = (1 << MAG_W) - 1;
    localparam logic [DATA_W:0]  FS    = (DATA_W + 1)'(FS_N);
    localparam logic [RAD_W-1:0] FS_SQ = RAD_W'(FS_N) * RAD_W'(FS_N);

    logic [DATA_W:0]  ext;
    logic [DATA_W:0]  mag;
    logic [RAD_W-1:0] mag_sq;

    always_comb begin
        ext    = {vd_i[DATA_W-1], vd_i};
        mag    = ext[DATA_W] ? (~ext + 1'b1) : ext;
        zero_o = (mag >= FS);
        mag_sq = RAD_W'(mag[MAG_W-1:0]) * RAD_W'(mag[MAG_W-1:0]);
        rad_o  = zero_o ? '0 : (FS_SQ - mag_sq);
    end
endmodule

// File: rtl/sqrtlim_divider.sv
module sqrtlim_divider #(
    parameter int RAD_W = 28,
    parameter int X_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [RAD_W-1:0] dividend_i,
    input  logic [X_W-1:0]   divisor_i,
    output logic             done_o,
    output logic [RAD_W-1:0] quotient_o
);
    localparam int CNT_W = $clog2(RAD_W);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [X_W-1:0]   rem;
        logic [RAD_W-1:0] quo;
        logic             done;
    } div_reg_t;

    div_reg_t r_d, r_q;
    logic [X_W:0] shifted;
    logic [X_W:0] diff;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        shifted  = {r_q.rem, r_q.quo[RAD_W-1]};
        diff     = shifted - {1'b0, divisor_i};
        if (start_i && !r_q.busy) begin
            r_d.busy = 1'b1;
            r_d.cnt  = '0;
            r_d.rem  = '0;
            r_d.quo  = dividend_i;
        end else if (r_q.busy) begin
            if (shifted >= {1'b0, divisor_i}) begin
                r_d.rem = diff[X_W-1:0];
                r_d.quo = {r_q.quo[RAD_W-2:0], 1'b1};
            end else begin
                r_d.rem = shifted[X_W-1:0];
                r_d.quo = {r_q.quo[RAD_W-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt == CNT_W'(RAD_W - 1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o     = r_q.done;
    assign quotient_o = r_q.quo;

    // R4: the returned quotient is the exact floor of dividend / divisor
    a_r4_floor_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((64'(quotient_o) * 64'(divisor_i) <= 64'(dividend_i)) &&
                    (64'(dividend_i) < (64'(quotient_o) + 64'd1) * 64'(divisor_i))));

    // R4: the caller never restarts the divider while it is working
    a_r4_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.busy |-> !start_i);
endmodule

// File: rtl/sqrtlim_newton.sv
module sqrtlim_newton #(
    parameter int DATA_W = 16,
    parameter int X_W    = 20,
    parameter int GUESS  = 500,
    parameter int ITERS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] vd_i,
    output logic              done_o,
    output logic [DATA_W-1:0] limit_o
);
    import sqrtlim_pkg::*;

    localparam int RAD_W = 2 * (DATA_W - 2);
    localparam int IT_W  = $clog2(ITERS + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IT_W-1:0]   it;
        logic [X_W-1:0]    x;
        logic [RAD_W-1:0]  rad;
        logic [DATA_W-1:0] lim;
        logic              done;
        logic              dstart;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    logic [RAD_W-1:0] rad_w;
    logic             zero_w;
    logic             div_done;
    logic [RAD_W-1:0] quo_w;
    logic [RAD_W:0]   sum_w;
    logic [X_W-1:0]   x_new;

    sqrtlim_radicand #(.DATA_W(DATA_W), .RAD_W(RAD_W)) u_rad (
        .vd_i   (vd_i),
        .rad_o  (rad_w),
        .zero_o (zero_w)
    );

    sqrtlim_divider #(.RAD_W(RAD_W), .X_W(X_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (r_q.dstart),
        .dividend_i (r_q.rad),
        .divisor_i  (r_q.x),
        .done_o     (div_done),
        .quotient_o (quo_w)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.dstart = 1'b0;
        sum_w      = (RAD_W + 1)'(r_q.x) + (RAD_W + 1)'(quo_w);
        x_new      = X_W'(sum_w >> 1);
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (zero_w) begin
                        r_d.lim  = '0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st     = ST_RUN;
                        r_d.rad    = rad_w;
                        r_d.x      = X_W'(GUESS);
                        r_d.it     = '0;
                        r_d.dstart = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (div_done) begin
                    r_d.x = x_new;
                    if (r_q.it == IT_W'(ITERS - 1)) begin
                        r_d.st   = ST_IDLE;
                        r_d.lim  = x_new[DATA_W-1:0];
                        r_d.done = 1'b1;
                    end else begin
                        r_d.it     = r_q.it + 1'b1;
                        r_d.dstart = 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign done_o  = r_q.done;
    assign limit_o = r_q.lim;

    // R5: the completion pulse never lasts two cycles
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the output only moves together with a completion pulse
    a_r6_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(limit_o));

    // R7: a strobe during a run does not disturb the captured radicand
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && start_i) |=> $stable(r_q.rad));

    // R9: the divisor handed to the divider is never zero
    a_r9_estimate_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (r_q.x != '0));

    // R9: each new estimate fits the estimate register
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && div_done) |-> (sum_w[RAD_W:X_W+1] == '0));
endmodule

// File: tb/sqrtlim_newton_bench.sv
module sqrtlim_newton_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] vd_i = '0;
    logic        done_o;
    logic [15:0] limit_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    sqrtlim_newton u_sqrtlim_newton (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .vd_i    (vd_i),
        .done_o  (done_o),
        .limit_o (limit_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected fewer than 190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic longint expect_limit(input int vd);
        longint m, a, x;
        m = (vd < 0) ? -vd : vd;
        if (m >= 16383) return 0;
        a = 64'd16383 * 64'd16383 - m * m;
        x = 500;
        for (int k = 0; k < 8; k++) x = (x + a / x) / 2;
        return x;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_one(input int vd, input string req);
        @(negedge clk);
        vd_i = 16'(vd);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(req, limit_o, expect_limit(vd));
        @(negedge clk);
        check("R5 pulse", done_o, 0);
    endtask

    initial begin
        longint held;
        repeat (3) @(negedge clk);
        check("R8 done", done_o, 0);
        check("R8 limit", limit_o, 0);
        rst_n = 1'b1;

        run_one(0, "R2 vd=0");
        check("R2 full scale", limit_o, expect_limit(0));
        run_one(1, "R2 vd=1");
        run_one(-1, "R1 sign vd=-1");
        run_one(16382, "R2 smallest radicand");
        run_one(-16382, "R1 neg smallest radicand");
        run_one(16383, "R3 vd=FS");
        run_one(-16383, "R3 vd=-FS");
        run_one(-32768, "R3 vd=min");
        run_one(32767, "R3 vd=max");
        run_one(11585, "R2 mid");
        for (int v = -16500; v <= 16500; v += 97) run_one(v, "R2 sweep");

        // R7: a second strobe in mid-run is ignored
        @(negedge clk);
        vd_i = 16'd100;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        vd_i = 16'hEC78;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check("R7 busy start", limit_o, expect_limit(100));

        // R6: output held while input changes without a strobe
        held = limit_o;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            vd_i = 16'(k * 1234);
            check("R6 held done", done_o, 0);
        end
        check("R6 held limit", limit_o, held);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule